// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for four-beat bursts into a synchronous memory array. A load captures a 17-bit start address together with the burst order requested on that cycle. Each later advance steps to the next beat. Only the two low address bits change from beat to beat, and the upper bits keep the value loaded for the whole burst.

Two orders are supported. In interleaved order, the low bits are the loaded low bits XOR the beat number. In linear order, the low bits are the loaded low bits plus the beat number, wrapping modulo four. A clock enable freezes the whole block while it is low.

The control is a four-state machine whose state is the beat number, so the beat index output is the state itself:
- The states are `BEAT0`, `BEAT1`, `BEAT2` and `BEAT3`.
- On an advance, the transitions are `BEAT0→BEAT1`, `BEAT1→BEAT2`, `BEAT2→BEAT3` and `BEAT3→BEAT0` (the wrap).
- A load goes from any state to `BEAT0` (the restart).
- A synchronous reset also forces `BEAT0`.
- With the clock enable low, the machine stays in its current state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to `BEAT0` (`beat_idx` = 0) with a stored address of 0 and interleaved order, regardless of `clk_en`.
- R2: A rising edge with `clk_en`=1 and `load_sel`=1 makes the next outputs `beat_idx`=0 and `beat_addr`=`start_addr`.
- R3: An advance (`clk_en`=1, `load_sel`=0) never changes `beat_addr[16:2]`.
- R4: An advance steps `beat_idx` by one modulo 4, so 3 is followed by 0.
- R5: With `clk_en`=0, `beat_addr` and `beat_idx` hold, and `load_sel`, `start_addr` and `order_sel` are ignored.
- R6: With interleaved order captured (`order_sel`=1 at load), `beat_addr[1:0]` = loaded `start_addr[1:0]` XOR `beat_idx`.
- R7: With linear order captured (`order_sel`=0 at load), `beat_addr[1:0]` = (loaded `start_addr[1:0]` + `beat_idx`) mod 4.
- R8: `order_sel` is sampled only on a load edge. Changing it between loads does not affect the address sequence.
- R9: The advance after `BEAT3` returns `beat_addr` to exactly the loaded start address.
- R10: A load in the middle of a burst takes priority over advancing and restarts at the new address on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; low holds all state |
| load_sel | input | 1 | 1 = load start address, 0 = advance one beat |
| start_addr | input | 17 | Burst start address, captured on load |
| order_sel | input | 1 | Burst order: 1 = interleaved (XOR), 0 = linear (modulo-4 add) |
| beat_addr | output | 17 | Current array address |
| beat_idx | output | 2 | Current beat number 0..3 |

## Verification
Two events can land on the same edge, and the bench provokes each one:
- A load can arrive while a burst is still in progress, for example on the `BEAT2` cycle. The new address and order must win over the pending advance.
- A load can arrive while `clk_en` is low. In that case the hold must win and the load must leave no trace.

A behavioural model updates its base, order and beat count at every edge, and the outputs are compared against it every cycle. A long stretch of random traffic with frequent mid-burst loads, order toggles and enable gaps follows the directed cases.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [BEAT_W-1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;
endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_sel,
    output logic [BEAT_W-1:0] beat_idx
);
    beat_state_t state_q;
    beat_state_t state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (load_sel) begin
            state_d = BEAT0;
        end else begin
            unique case (state_q)
                BEAT0: state_d = BEAT1;
                BEAT1: state_d = BEAT2;
                BEAT2: state_d = BEAT3;
                BEAT3: state_d = BEAT0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BEAT0;
        end else if (clk_en) begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            BEAT0: beat_idx = 2'd0;
            BEAT1: beat_idx = 2'd1;
            BEAT2: beat_idx = 2'd2;
            BEAT3: beat_idx = 2'd3;
        endcase
    end
endmodule

// File: rtl/burst_base_hold.sv
module burst_base_hold
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_sel,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] base_addr,
    output burst_order_t      base_order
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr  <= '0;
            base_order <= ORD_INTERLEAVE;
        end else if (clk_en && load_sel) begin
            base_addr  <= start_addr;
            base_order <= burst_order_t'(order_sel);
        end
    end
endmodule

// File: rtl/burst_low_combine.sv
module burst_low_combine
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat_idx,
    input  burst_order_t      order,
    output logic [BEAT_W-1:0] addr_lo
);
    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: addr_lo = base_lo ^ beat_idx;
            ORD_LINEAR:     addr_lo = base_lo + beat_idx;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_sel,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [1:0]        beat_idx
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_addr;
    burst_order_t      base_order;
    logic [BEAT_W-1:0] idx;
    logic [BEAT_W-1:0] addr_lo;

    burst_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .load_sel (load_sel),
        .beat_idx (idx)
    );

    burst_base_hold #(.ADDR_W(ADDR_W)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load_sel   (load_sel),
        .start_addr (start_addr),
        .order_sel  (order_sel),
        .base_addr  (base_addr),
        .base_order (base_order)
    );

    burst_low_combine u_low (
        .base_lo  (base_addr[BEAT_W-1:0]),
        .beat_idx (idx),
        .order    (base_order),
        .addr_lo  (addr_lo)
    );

    // the upper bits stay at the loaded value for the whole burst
    assign beat_addr = {base_addr[ADDR_W-1 -: HI_W], addr_lo};
    assign beat_idx  = idx;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              load_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [1:0]        beat_idx
);
    logic [1:0] lo_seen;
    logic       ord_seen;
    logic       past_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_seen  <= 2'd0;
            ord_seen <= 1'b1;
        end else if (clk_en && load_sel) begin
            lo_seen  <= start_addr[1:0];
            ord_seen <= order_sel;
        end
    end

    always_ff @(posedge clk) past_valid <= 1'b1;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (beat_idx == 2'd0 && beat_addr == '0)); // R1
    AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load_sel) |=> (beat_idx == 2'd0 && beat_addr == $past(start_addr))); // R2
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load_sel) |=> (beat_addr[ADDR_W-1:2] == $past(beat_addr[ADDR_W-1:2]))); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load_sel) |=> (beat_idx == $past(beat_idx) + 2'd1)); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(beat_addr) && $stable(beat_idx))); // R5
    AST_XOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        ord_seen |-> (beat_addr[1:0] == (lo_seen ^ beat_idx))); // R6
    AST_ADD_ORDER: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        !ord_seen |-> (beat_addr[1:0] == 2'(lo_seen + beat_idx))); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .load_sel   (load_sel),
    .start_addr (start_addr),
    .order_sel  (order_sel),
    .beat_addr  (beat_addr),
    .beat_idx   (beat_idx)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          load_sel = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] beat_addr;
    logic [1:0]    beat_idx;

    integer checks = 0;
    integer errors = 0;
    bit     done = 1'b0;

    // behavioural reference
    integer m_base = 0;
    integer m_xor  = 1;
    integer m_idx  = 0;

    always #4 clk = ~clk;

    burst_addr_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load_sel   (load_sel),
        .start_addr (start_addr),
        .order_sel  (order_sel),
        .beat_addr  (beat_addr),
        .beat_idx   (beat_idx)
    );

    function automatic integer exp_addr();
        integer lo;
        if (m_xor != 0) lo = (m_base ^ m_idx) & 3;
        else            lo = (m_base + m_idx) % 4;
        return (m_base & ~3) | lo;
    endfunction

    task automatic compare(input string req);
        checks++;
        if (beat_addr !== AW'(exp_addr()) || beat_idx !== 2'(m_idx)) begin
            errors++;
            $display("FAIL %s: addr=%h idx=%0d expected addr=%h idx=%0d",
                     req, beat_addr, beat_idx, AW'(exp_addr()), m_idx);
        end
    endtask

    // one clock: drive at the falling edge, update the model at the rising edge, compare after it
    task automatic step(input bit rs, input bit ce, input bit ld,
                        input integer addr, input bit ord, input string req);
        @(negedge clk);
        rst_n = ~rs; clk_en = ce; load_sel = ld;
        start_addr = AW'(addr); order_sel = ord;
        @(posedge clk);
        if (rs) begin
            m_base = 0; m_xor = 1; m_idx = 0;
        end else if (ce) begin
            if (ld) begin
                m_base = addr & ((1 << AW) - 1); m_xor = ord; m_idx = 0;
            end else begin
                m_idx = (m_idx + 1) % 4;
            end
        end
        #1;
        compare(req);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1, 0, 1, 'h1FFFF, 0, "R1");            // reset wins over inputs
        step(1, 1, 0, 0, 0, "R1");
        // R2 R6 R9 interleaved from low bits 01: 01 00 11 10 then back
        step(0, 1, 1, 'h1ABC9, 1, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 0, "R9");
        // R7 linear from low bits 10: 10 11 00 01 then back
        step(0, 1, 1, 'h0F00E, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 'h12345, 1, "R7");
        step(0, 1, 0, 0, 1, "R9");
        // R5 hold with load requested while disabled
        step(0, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 'h15555, 1, "R5");
        step(0, 1, 0, 0, 1, "R4");
        // R8 order toggles between loads have no effect
        step(0, 1, 1, 'h00003, 1, "R2");
        step(0, 1, 0, 0, 0, "R8");
        step(0, 1, 0, 0, 1, "R8");
        step(0, 1, 0, 0, 0, "R8");
        // R10 load in the middle of a burst
        step(0, 1, 1, 'h10001, 0, "R10");
        step(0, 1, 0, 0, 1, "R10");
        step(0, 1, 1, 'h0AAA2, 1, "R10");
        step(0, 1, 0, 0, 0, "R3");
        step(1, 1, 1, 'h1FFFF, 0, "R1");            // reset in mid burst
        step(0, 1, 0, 0, 0, "R4");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            integer r;
            r = $urandom % 100;
            step(r < 1, (r % 5) != 0, ($urandom % 4) == 0,
                 $urandom % (1 << AW), $urandom % 2, "R4");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule